// File: doc/BRIEF.md
# USB Host Port Control and Status Register

This block is the host-side port register of a USB controller together with the small state machine that sequences the root port. Software sets a power bit to drive VBUS onto the cable. Once a device is seen on the line, the block latches a sticky connect event and raises its interrupt. Software then holds a reset bit for as long as the bus reset must last. The block times nothing itself: that window belongs to software, and the protocol asks for at least 10 ms.

When the reset bit goes back to 0, the block enables the port. It captures the speed code that the PHY reports and flags a sticky enable-change event. An enabled port that loses its device or its power drops back to disabled and flags enable-change again.

The register is eight bits wide. Bits 0, 2 and 7:6 are read-only. Bits 1 and 3 clear when 1 is written to them. Bits 4 and 5 are ordinary read/write control bits. A read returns the current contents with no wait state.

Top module: `usbh_port_ctrl`

## Requirements
- R1: After synchronous reset, reg_rdata is 0x00 and vbus_drv, bus_reset_drv and irq are all 0.
- R2: Bit 5 (power) is read/write, and vbus_drv follows it from the clock edge that writes it.
- R3: Bit 1 (connect event) sets when line_attached is high while power is on and the device was not already present. This includes power being switched on with a device already attached. Bit 0 reads 1 while a device is attached with power on. An attach while power is off sets neither bit.
- R4: Bits 1 and 3 clear only when 1 is written to them. Writing 0 to either leaves it unchanged.
- R5: bus_reset_drv is high while bit 4 (reset) is 1 with power on and a device attached.
- R6: When bit 4 returns to 0 during bus reset, bit 2 (enabled) becomes 1, bits 7:6 load phy_speed (00 high, 01 full, 10 low), and bit 3 (enable change) sets.
- R7: An enabled port that sees line_attached go low, or power cleared, clears bit 2 and sets bit 3.
- R8: irq equals bit 1 OR bit 3 of the register.
- R9: Once captured, bits 7:6 hold their value while phy_speed changes.
- R10: Writes to bits 0, 2, 6 and 7 have no effect.
- R11: Setting bit 4 with no device attached drives no bus reset. Bus reset starts if a device then attaches while bit 4 is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| line_attached | input | 1 | Line-state device-present indication, synchronous |
| phy_speed | input | SPD_W | Speed code enumerated by the PHY |
| vbus_drv | output | 1 | Drives VBUS onto the port |
| bus_reset_drv | output | 1 | Drives bus reset on the link |
| irq | output | 1 | Port interrupt |

## Verification
The properties assume that line_attached is already synchronous to clk and free of glitches. They also assume that phy_speed is valid at the cycle in which software releases bus reset. The stimulus changes line_attached and phy_speed only on the falling edge. Each action is held for several cycles before the next one, so the port state machine settles between steps. A single write can carry a reset release and a status clear together. Because that write lands before the block raises the new event, the two never collide on one edge.

// File: rtl/usbh_port_pkg.sv
package usbh_port_pkg;
  localparam int REG_BITS  = 8;
  localparam int SPD_BITS  = 2;
  localparam int B_PRESENT = 0;
  localparam int B_CEVT    = 1;
  localparam int B_EN      = 2;
  localparam int B_ECHG    = 3;
  localparam int B_RST     = 4;
  localparam int B_PWR     = 5;
  localparam int B_SPD     = 6;

  typedef enum logic [2:0] {
    PS_OFF,
    PS_WAIT,
    PS_ATTACHED,
    PS_RESET,
    PS_ENABLED
  } port_state_e;
endpackage

// File: rtl/usbh_port_detect.sv
module usbh_port_detect (
  input  logic clk,
  input  logic rst,
  input  logic pwr_on,
  input  logic line_attached,
  output logic dev_present,
  output logic conn_pulse
);
  always_ff @(posedge clk) begin
    if (rst) dev_present <= 1'b0;
    else     dev_present <= pwr_on & line_attached;
  end

  // new presence while powered raises one event
  assign conn_pulse = pwr_on & line_attached & ~dev_present;
endmodule

// File: rtl/usbh_port_fsm.sv
module usbh_port_fsm
  import usbh_port_pkg::*;
#(
  parameter int SPD_W = SPD_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_on,
  input  logic             rst_req,
  input  logic             line_attached,
  input  logic [SPD_W-1:0] phy_spd,
  output logic             port_en,
  output logic             bus_rst,
  output logic [SPD_W-1:0] spd_q,
  output logic             en_chg_pulse
);
  port_state_e st_q, st_d;
  logic        capture;

  always_comb begin
    st_d         = st_q;
    capture      = 1'b0;
    en_chg_pulse = 1'b0;
    unique case (st_q)
      PS_OFF:      if (pwr_on) st_d = PS_WAIT;
      PS_WAIT: begin
        if (!pwr_on)            st_d = PS_OFF;
        else if (line_attached) st_d = PS_ATTACHED;
      end
      PS_ATTACHED: begin
        if (!pwr_on)             st_d = PS_OFF;
        else if (!line_attached) st_d = PS_WAIT;
        else if (rst_req)        st_d = PS_RESET;
      end
      PS_RESET: begin
        if (!pwr_on)             st_d = PS_OFF;
        else if (!line_attached) st_d = PS_WAIT;
        else if (!rst_req) begin
          st_d         = PS_ENABLED;
          capture      = 1'b1;
          en_chg_pulse = 1'b1;
        end
      end
      PS_ENABLED: begin
        if (!pwr_on) begin
          st_d         = PS_OFF;
          en_chg_pulse = 1'b1;
        end else if (!line_attached) begin
          st_d         = PS_WAIT;
          en_chg_pulse = 1'b1;
        end else if (rst_req) begin
          st_d = PS_RESET;
        end
      end
      default: st_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PS_OFF;
      spd_q <= '0;
    end else begin
      st_q <= st_d;
      if (capture) spd_q <= phy_spd;
    end
  end

  assign port_en = (st_q == PS_ENABLED);
  assign bus_rst = (st_q == PS_RESET);
endmodule

// File: rtl/usbh_port_csr.sv
module usbh_port_csr
  import usbh_port_pkg::*;
#(
  parameter int REG_W = REG_BITS,
  parameter int SPD_W = SPD_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             conn_pulse,
  input  logic             dev_present,
  input  logic             port_en,
  input  logic             en_chg_pulse,
  input  logic [SPD_W-1:0] spd,
  output logic             pwr_q,
  output logic             rst_q,
  output logic [REG_W-1:0] rdata,
  output logic             irq
);
  logic cevt_q, cevt_d, echg_q, echg_d;

  // W1C: a pending event outranks the clear
  always_comb begin
    cevt_d = conn_pulse   | (cevt_q & ~(we & wdata[B_CEVT]));
    echg_d = en_chg_pulse | (echg_q & ~(we & wdata[B_ECHG]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q  <= 1'b0;
      rst_q  <= 1'b0;
      cevt_q <= 1'b0;
      echg_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (we) begin
        pwr_q <= wdata[B_PWR];
        rst_q <= wdata[B_RST];
      end
      cevt_q <= cevt_d;
      echg_q <= echg_d;
      irq    <= cevt_d | echg_d;
    end
  end

  always_comb begin
    rdata                      = '0;
    rdata[B_PRESENT]           = dev_present;
    rdata[B_CEVT]              = cevt_q;
    rdata[B_EN]                = port_en;
    rdata[B_ECHG]              = echg_q;
    rdata[B_RST]               = rst_q;
    rdata[B_PWR]               = pwr_q;
    rdata[B_SPD +: SPD_W]      = spd;
  end
endmodule

// File: rtl/usbh_port_ctrl.sv
module usbh_port_ctrl
  import usbh_port_pkg::*;
#(
  parameter int REG_W = REG_BITS,
  parameter int SPD_W = SPD_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             line_attached,
  input  logic [SPD_W-1:0] phy_speed,
  output logic             vbus_drv,
  output logic             bus_reset_drv,
  output logic             irq
);
  logic             pwr_q, rst_q;
  logic             dev_present, conn_pulse;
  logic             port_en, en_chg_pulse;
  logic [SPD_W-1:0] spd_q;

  usbh_port_detect u_detect (
    .clk          (clk),
    .rst          (rst),
    .pwr_on       (pwr_q),
    .line_attached(line_attached),
    .dev_present  (dev_present),
    .conn_pulse   (conn_pulse)
  );

  usbh_port_fsm #(.SPD_W(SPD_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .pwr_on       (pwr_q),
    .rst_req      (rst_q),
    .line_attached(line_attached),
    .phy_spd      (phy_speed),
    .port_en      (port_en),
    .bus_rst      (bus_reset_drv),
    .spd_q        (spd_q),
    .en_chg_pulse (en_chg_pulse)
  );

  usbh_port_csr #(.REG_W(REG_W), .SPD_W(SPD_W)) u_csr (
    .clk         (clk),
    .rst         (rst),
    .we          (reg_we),
    .wdata       (reg_wdata),
    .conn_pulse  (conn_pulse),
    .dev_present (dev_present),
    .port_en     (port_en),
    .en_chg_pulse(en_chg_pulse),
    .spd         (spd_q),
    .pwr_q       (pwr_q),
    .rst_q       (rst_q),
    .rdata       (reg_rdata),
    .irq         (irq)
  );

  assign vbus_drv = pwr_q;
endmodule

// File: rtl/usbh_port_ctrl_chk.sv
module usbh_port_ctrl_chk
  import usbh_port_pkg::*;
#(
  parameter int REG_W = REG_BITS,
  parameter int SPD_W = SPD_BITS
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             line_attached,
  input logic [SPD_W-1:0] phy_speed,
  input logic             vbus_drv,
  input logic             bus_reset_drv,
  input logic             irq
);
  assert_irq_or_R8: assert property (@(posedge clk) disable iff (rst)
    irq == (reg_rdata[B_CEVT] | reg_rdata[B_ECHG]));

  assert_vbus_write_R2: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> vbus_drv == $past(reg_wdata[B_PWR]));

  assert_busrst_gated_R5: assert property (@(posedge clk) disable iff (rst)
    bus_reset_drv |-> $past(reg_rdata[B_RST] && reg_rdata[B_PWR]));

  assert_enable_flags_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rdata[B_EN]) |-> reg_rdata[B_ECHG]);

  assert_speed_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[B_EN] && $past(reg_rdata[B_EN])) |-> $stable(reg_rdata[B_SPD +: SPD_W]));

  assert_conn_powered_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rdata[B_CEVT]) |-> $past(vbus_drv));
endmodule

bind usbh_port_ctrl usbh_port_ctrl_chk #(.REG_W(REG_W), .SPD_W(SPD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_we       (reg_we),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .line_attached(line_attached),
  .phy_speed    (phy_speed),
  .vbus_drv     (vbus_drv),
  .bus_reset_drv(bus_reset_drv),
  .irq          (irq)
);

// File: tb/usbh_port_ctrl_tb.sv
`timescale 1ns/1ps
module usbh_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       line_attached = 1'b0;
  logic [1:0] phy_speed = 2'b00;
  logic       vbus_drv, bus_reset_drv, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] rdata;
    logic       vbus;
    logic       brst;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  event sample_ev;

  always #2.5 clk = ~clk;

  usbh_port_ctrl u_dut (
    .clk          (clk),
    .rst          (rst),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .line_attached(line_attached),
    .phy_speed    (phy_speed),
    .vbus_drv     (vbus_drv),
    .bus_reset_drv(bus_reset_drv),
    .irq          (irq)
  );

  // monitor: pop expected item and compare against the ports
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (reg_rdata !== e.rdata || vbus_drv !== e.vbus ||
            bus_reset_drv !== e.brst || irq !== e.irq) begin
          failures++;
          $display("FAIL %s: got rdata=%02h vbus=%0b brst=%0b irq=%0b exp rdata=%02h vbus=%0b brst=%0b irq=%0b",
                   e.tag, reg_rdata, vbus_drv, bus_reset_drv, irq,
                   e.rdata, e.vbus, e.brst, e.irq);
        end
      end
    end
  end

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic expect_ports(input logic [7:0] rd, input logic v, input logic b,
                              input logic i, input string tag);
    exp_t e;
    settle();
    e.rdata = rd; e.vbus = v; e.brst = b; e.irq = i; e.tag = tag;
    exp_q.push_back(e);
    ->sample_ev;
    #0.1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_ports(8'h00, 0, 0, 0, "R1 reset state");

    line_attached = 1'b1;
    expect_ports(8'h00, 0, 0, 0, "R3 attach unpowered ignored");

    reg_write(8'h20);
    expect_ports(8'h23, 1, 0, 1, "R2 R3 power on with device present");

    reg_write(8'hE5);
    expect_ports(8'h23, 1, 0, 1, "R10 R4 read-only write and zero to W1C");

    reg_write(8'h22);
    expect_ports(8'h21, 1, 0, 0, "R4 R8 clear connect event");

    phy_speed = 2'b01;
    reg_write(8'h30);
    expect_ports(8'h31, 1, 1, 0, "R5 bus reset driven");

    phy_speed = 2'b10;
    reg_write(8'h20);
    expect_ports(8'hAD, 1, 0, 1, "R6 release enables and captures low speed");

    phy_speed = 2'b00;
    expect_ports(8'hAD, 1, 0, 1, "R9 speed held");

    reg_write(8'h28);
    expect_ports(8'hA5, 1, 0, 0, "R4 R8 clear enable change");

    line_attached = 1'b0;
    expect_ports(8'hA8, 1, 0, 1, "R7 disconnect disables port");

    reg_write(8'h28);
    expect_ports(8'hA0, 1, 0, 0, "R4 clear after disconnect");

    reg_write(8'h30);
    expect_ports(8'hB0, 1, 0, 0, "R11 reset bit without device");

    line_attached = 1'b1;
    expect_ports(8'hB3, 1, 1, 1, "R11 R3 R5 attach during held reset");

    reg_write(8'h22);
    expect_ports(8'h2D, 1, 0, 1, "R6 R4 release with high speed and clear");

    reg_write(8'h08);
    expect_ports(8'h08, 0, 0, 1, "R7 R2 power off disables port");

    reg_write(8'h08);
    expect_ports(8'h00, 0, 0, 0, "R4 R8 final clear");

    settle();
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: got %0d pending items, expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule